// File: doc/BRIEF.md
# Two-Wire Serial Slave with Write-Enable Gating

This block is the serial-bus front end of a small device that holds a byte memory, a bank of clock/control registers and a one-byte protection status register. It watches a two-wire bus (clock and data, both open-drain), oversampled by a fast system clock. It recognises its own device address and takes a two-byte word address. It then either accepts a single data byte for writing or streams bytes back for reading. The data line is driven only through an output enable, and only ever pulled low.

Writes are filtered at acknowledge time. A data byte is refused, and never stored, when the protection bits do not allow it. Only one data byte is taken per write. The control bank opens only after a two-step unlock through the status register. An accepted byte is committed when the bus stop arrives. After that the block stays deaf to the bus for a fixed number of system clocks, to model the internal programming time. A `busy` output shows this interval.

Top module: `i2cp_slave`

## Requirements
- R1: The first byte after a start is the device address byte. Bits [7:4] hold the device identifier (parameter `DEV_ID`, default 4'hD). Bits [3:1] hold the select code (`DEV_SEL`, default 3'b011). Bit 0 selects the direction, 1 for read. The byte is acknowledged only when the identifier and the select code both match. Otherwise the block releases the line and waits for a new start.
- R2: For a write, the two word-address bytes (high byte first) are always acknowledged. The high byte selects the region: 00h is the 64-byte memory, indexed by the low 6 bits. 01h is the 8-entry control bank, indexed by the low 3 bits. 02h is the status register. Any other value is unmapped, and a data byte for it is refused. An accepted data byte is stored only when the stop that ends the transfer arrives.
- R3: Only the first data byte of a write can be accepted. Any further data byte in the same transfer is not acknowledged and not written. This applies in particular to a second status-register byte.
- R4: Status bit 1 is the write-enable flag. While it is 0, a data byte aimed at the memory or the control bank is not acknowledged and changes nothing.
- R5: Writing the status register with 02h sets the write-enable flag and clears bit 2 (control enable). Writing 06h while write-enable is set sets both flags. Writing 00h clears both. A control-bank data byte is acknowledged only while both flags are set. Status writes themselves are always acknowledged (first byte only). Reading the status register returns bit 2 = control enable and bit 1 = write enable, with all other bits 0.
- R6: In a read, the block shifts out 8 bits, most significant first, and releases the line for the 9th clock. When the master acknowledges, the block sends the next byte.
- R7: When the master does not acknowledge a read byte, the block stops driving. It keeps the line released through any further clocks until a start or a stop.
- R8: A stop that ends a write with an accepted byte starts an internal write interval. `busy` is high for `WR_CYCLES` system clocks. During this interval the block does not drive the data line and ignores every start, stop and address byte.
- R9: After each byte it sends, the block advances the word address. The address wraps within the region: modulo 64 in the memory, modulo 8 in the control bank, and unchanged on the status register.
- R10: A repeated start restarts at the device address byte and checks it again. It keeps the word address just loaded, which allows a random read. It also discards a data byte that was accepted but not yet committed.
- R11: After reset, `sda_oe` and `busy` are 0 and all memory, control and status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND of all drivers) |
| sda_oe | output | 1 | When 1, the pad pulls the data line low; never drives high |
| busy | output | 1 | High during the internal write interval |

## Verification
The functions most likely to collide are the stop that commits a write and the protocol engine's detection of the next start. A start that arrives just after the commit falls inside the write interval and must be ignored. The bench issues a new device-address byte directly after a write's stop and expects it to go unacknowledged with `busy` still high. A later read-back then shows that only the committed byte landed. A second collision is the repeated start that lands while a data byte is pending: the bench reads the same location back within that transfer, and after the stop it expects the old value and no write interval.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 16;
    localparam int MEM_DEPTH  = 64;
    localparam int CTRL_DEPTH = 8;
    localparam int MEM_AW     = $clog2(MEM_DEPTH);
    localparam int CTRL_AW    = $clog2(CTRL_DEPTH);

    localparam logic [7:0] HI_MEM  = 8'h00;
    localparam logic [7:0] HI_CTRL = 8'h01;
    localparam logic [7:0] HI_STAT = 8'h02;

    localparam int WEL_BIT  = 1;
    localparam int RWEL_BIT = 2;

    localparam logic [7:0] STAT_CMD_CLR  = 8'h00;
    localparam logic [7:0] STAT_CMD_WEL  = 8'h02;
    localparam logic [7:0] STAT_CMD_BOTH = 8'h06;

    typedef enum logic [1:0] {
        RG_MEM,
        RG_CTRL,
        RG_STAT,
        RG_NONE
    } region_t;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_RECV,
        FS_ACK,
        FS_TX,
        FS_MACK,
        FS_BUSY
    } fsm_st_t;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_DATA
    } phase_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic region_t region_of(input logic [7:0] hi);
        case (hi)
            HI_MEM:  return RG_MEM;
            HI_CTRL: return RG_CTRL;
            HI_STAT: return RG_STAT;
            default: return RG_NONE;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
        logic [7:0] lo;
        lo = a[7:0];
        case (region_of(a[15:8]))
            RG_MEM:  lo[MEM_AW-1:0]  = lo[MEM_AW-1:0] + MEM_AW'(1);
            RG_CTRL: lo[CTRL_AW-1:0] = lo[CTRL_AW-1:0] + CTRL_AW'(1);
            default: lo = a[7:0];
        endcase
        return {a[15:8], lo};
    endfunction

    function automatic logic data_permit(input region_t r, input logic wel, input logic rwel);
        case (r)
            RG_STAT: return 1'b1;
            RG_MEM:  return wel;
            RG_CTRL: return wel & rwel;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/i2cp_sync_edge.sv
module i2cp_sync_edge
    import i2cp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);

    logic [SYNC_STAGES:0] scl_pipe;
    logic [SYNC_STAGES:0] sda_pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-1:0], sda_i};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_pipe[SYNC_STAGES-1];
    assign scl_old = scl_pipe[SYNC_STAGES];
    assign sda_now = sda_pipe[SYNC_STAGES-1];
    assign sda_old = sda_pipe[SYNC_STAGES];

    always_comb begin
        ev_o.sda      = sda_now;
        ev_o.scl_rise = scl_now & ~scl_old;
        ev_o.scl_fall = ~scl_now & scl_old;
        ev_o.start    = scl_now & scl_old & sda_old & ~sda_now;
        ev_o.stop     = scl_now & scl_old & ~sda_old & sda_now;
    end

endmodule

// File: rtl/i2cp_busy_timer.sv
module i2cp_busy_timer #(
    parameter int WR_CYCLES = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o
);

    localparam int CW = $clog2(WR_CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (start_i) begin
            remain <= CW'(WR_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - CW'(1);
        end
    end

    assign busy_o = (remain != '0);

endmodule

// File: rtl/i2cp_regfile.sv
module i2cp_regfile
    import i2cp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit_i,
    input  wr_req_t           req_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              wel_o,
    output logic              rwel_o
);

    logic [BYTE_W-1:0] mem  [MEM_DEPTH];
    logic [BYTE_W-1:0] ctrl [CTRL_DEPTH];
    logic wel, rwel;

    region_t wr_rg;
    assign wr_rg = region_of(req_i.addr[15:8]);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
        end else if (commit_i && wr_rg == RG_MEM && wel) begin
            mem[req_i.addr[MEM_AW-1:0]] <= req_i.data;
        end
    end

    for (genvar g = 0; g < CTRL_DEPTH; g++) begin : g_ctrl
        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl[g] <= '0;
            end else if (commit_i && wr_rg == RG_CTRL && wel && rwel &&
                         req_i.addr[CTRL_AW-1:0] == CTRL_AW'(g)) begin
                ctrl[g] <= req_i.data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wel  <= 1'b0;
            rwel <= 1'b0;
        end else if (commit_i && wr_rg == RG_STAT) begin
            case (req_i.data)
                STAT_CMD_CLR: begin
                    wel  <= 1'b0;
                    rwel <= 1'b0;
                end
                STAT_CMD_WEL: begin
                    wel  <= 1'b1;
                    rwel <= 1'b0;
                end
                STAT_CMD_BOTH: begin
                    if (wel) rwel <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    logic [BYTE_W-1:0] stat_val;
    always_comb begin
        stat_val           = '0;
        stat_val[WEL_BIT]  = wel;
        stat_val[RWEL_BIT] = rwel;
    end

    always_comb begin
        case (region_of(rd_addr_i[15:8]))
            RG_MEM:  rd_data_o = mem[rd_addr_i[MEM_AW-1:0]];
            RG_CTRL: rd_data_o = ctrl[rd_addr_i[CTRL_AW-1:0]];
            RG_STAT: rd_data_o = stat_val;
            default: rd_data_o = '0;
        endcase
    end

    logic unused_hi_bits;
    assign unused_hi_bits = ^{rd_addr_i[7:MEM_AW], req_i.addr[7:MEM_AW]};

    assign wel_o  = wel;
    assign rwel_o = rwel;

endmodule

// File: rtl/i2cp_bus_fsm.sv
module i2cp_bus_fsm
    import i2cp_pkg::*;
#(
    parameter logic [3:0] DEV_ID  = 4'hD,
    parameter logic [2:0] DEV_SEL = 3'b011
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev_i,
    input  logic              busy_i,
    input  logic              wel_i,
    input  logic              rwel_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              sda_oe_o,
    output logic              commit_o,
    output wr_req_t           commit_req_o
);

    fsm_st_t           st;
    phase_t            ph;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] sh;
    logic [ADDR_W-1:0] addr;
    logic              rd_mode;
    logic              ack_q;
    logic              mack;
    logic              got_data;
    logic              pend;
    wr_req_t           pend_req;

    logic ack_now;
    always_comb begin
        case (ph)
            PH_DEV:  ack_now = (sh[7:1] == {DEV_ID, DEV_SEL});
            PH_DATA: ack_now = !got_data &&
                               data_permit(region_of(addr[15:8]), wel_i, rwel_i);
            default: ack_now = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= FS_IDLE;
            ph           <= PH_DEV;
            cnt          <= '0;
            sh           <= '0;
            addr         <= '0;
            rd_mode      <= 1'b0;
            ack_q        <= 1'b0;
            mack         <= 1'b0;
            got_data     <= 1'b0;
            pend         <= 1'b0;
            pend_req     <= '0;
            sda_oe_o     <= 1'b0;
            commit_o     <= 1'b0;
            commit_req_o <= '0;
        end else begin
            commit_o <= 1'b0;
            if (st == FS_BUSY) begin
                sda_oe_o <= 1'b0;
                if (!busy_i && !commit_o) st <= FS_IDLE;
            end else if (ev_i.stop) begin
                sda_oe_o <= 1'b0;
                if (pend) begin
                    commit_o     <= 1'b1;
                    commit_req_o <= pend_req;
                    pend         <= 1'b0;
                    st           <= FS_BUSY;
                end else begin
                    st <= FS_IDLE;
                end
            end else if (ev_i.start) begin
                sda_oe_o <= 1'b0;
                st       <= FS_RECV;
                ph       <= PH_DEV;
                cnt      <= '0;
                got_data <= 1'b0;
                pend     <= 1'b0;
            end else begin
                case (st)
                    FS_RECV: begin
                        if (ev_i.scl_rise && cnt < 4'd8) begin
                            sh  <= {sh[6:0], ev_i.sda};
                            cnt <= cnt + 4'd1;
                        end
                        if (ev_i.scl_fall && cnt == 4'd8) begin
                            sda_oe_o <= ack_now;
                            ack_q    <= ack_now;
                            st       <= FS_ACK;
                            case (ph)
                                PH_DEV: rd_mode <= sh[0];
                                PH_AHI: addr[15:8] <= sh;
                                PH_ALO: addr[7:0]  <= sh;
                                PH_DATA: begin
                                    got_data <= 1'b1;
                                    if (ack_now) begin
                                        pend          <= 1'b1;
                                        pend_req.addr <= addr;
                                        pend_req.data <= sh;
                                    end
                                end
                                default: ;
                            endcase
                        end
                    end
                    FS_ACK: begin
                        if (ev_i.scl_fall) begin
                            sda_oe_o <= 1'b0;
                            cnt      <= '0;
                            if (!ack_q) begin
                                st <= FS_IDLE;
                            end else begin
                                case (ph)
                                    PH_DEV: begin
                                        if (rd_mode) begin
                                            sh       <= rd_data_i;
                                            sda_oe_o <= ~rd_data_i[7];
                                            st       <= FS_TX;
                                        end else begin
                                            ph <= PH_AHI;
                                            st <= FS_RECV;
                                        end
                                    end
                                    PH_AHI: begin
                                        ph <= PH_ALO;
                                        st <= FS_RECV;
                                    end
                                    default: begin
                                        ph <= PH_DATA;
                                        st <= FS_RECV;
                                    end
                                endcase
                            end
                        end
                    end
                    FS_TX: begin
                        if (ev_i.scl_fall) begin
                            if (cnt == 4'd7) begin
                                sda_oe_o <= 1'b0;
                                addr     <= next_addr(addr);
                                st       <= FS_MACK;
                            end else begin
                                sh       <= {sh[6:0], 1'b0};
                                sda_oe_o <= ~sh[6];
                                cnt      <= cnt + 4'd1;
                            end
                        end
                    end
                    FS_MACK: begin
                        if (ev_i.scl_rise) mack <= ~ev_i.sda;
                        if (ev_i.scl_fall) begin
                            cnt <= '0;
                            if (mack) begin
                                sh       <= rd_data_i;
                                sda_oe_o <= ~rd_data_i[7];
                                st       <= FS_TX;
                            end else begin
                                sda_oe_o <= 1'b0;
                                st       <= FS_IDLE;
                            end
                        end
                    end
                    default: sda_oe_o <= 1'b0;
                endcase
            end
        end
    end

    assign addr_o = addr;

endmodule

// File: rtl/i2cp_slave.sv
module i2cp_slave
    import i2cp_pkg::*;
#(
    parameter logic [3:0] DEV_ID      = 4'hD,
    parameter logic [2:0] DEV_SEL     = 3'b011,
    parameter int         WR_CYCLES   = 200,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    output logic busy
);

    bus_ev_t           ev;
    logic              stop_det;
    logic              commit;
    wr_req_t           commit_req;
    logic [ADDR_W-1:0] commit_addr;
    logic [ADDR_W-1:0] cur_addr;
    logic [BYTE_W-1:0] rd_data;
    logic              wel;
    logic              rwel;

    i2cp_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    i2cp_bus_fsm #(.DEV_ID(DEV_ID), .DEV_SEL(DEV_SEL)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .ev_i         (ev),
        .busy_i       (busy),
        .wel_i        (wel),
        .rwel_i       (rwel),
        .rd_data_i    (rd_data),
        .addr_o       (cur_addr),
        .sda_oe_o     (sda_oe),
        .commit_o     (commit),
        .commit_req_o (commit_req)
    );

    i2cp_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .commit_i  (commit),
        .req_i     (commit_req),
        .rd_addr_i (cur_addr),
        .rd_data_o (rd_data),
        .wel_o     (wel),
        .rwel_o    (rwel)
    );

    i2cp_busy_timer #(.WR_CYCLES(WR_CYCLES)) u_busy (
        .clk     (clk),
        .rst     (rst),
        .start_i (commit),
        .busy_o  (busy)
    );

    assign stop_det    = ev.stop;
    assign commit_addr = commit_req.addr;

endmodule

// File: rtl/i2cp_slave_chk.sv
module i2cp_slave_chk
    import i2cp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              sda_oe,
    input logic              stop_det,
    input logic              commit,
    input logic [ADDR_W-1:0] commit_addr,
    input logic              wel,
    input logic              rwel
);

    logic unused_lo;
    assign unused_lo = ^commit_addr[7:0];

    AST_BUSY_RELEASED: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_oe);                                           // R8

    AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(commit));                              // R8

    AST_NO_COMMIT_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        commit |-> !busy);                                           // R8

    AST_COMMIT_AT_STOP: assert property (@(posedge clk) disable iff (rst)
        commit |-> $past(stop_det));                                 // R2

    AST_MEM_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
        (commit && region_of(commit_addr[15:8]) == RG_MEM) |-> wel);  // R4

    AST_CTRL_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
        (commit && region_of(commit_addr[15:8]) == RG_CTRL) |-> (wel && rwel)); // R5

endmodule

bind i2cp_slave i2cp_slave_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .sda_oe      (sda_oe),
    .stop_det    (stop_det),
    .commit      (commit),
    .commit_addr (commit_addr),
    .wel         (wel),
    .rwel        (rwel)
);

// File: tb/i2cp_slave_tb.sv
module i2cp_slave_tb;

    localparam int Q = 10;
    localparam logic [7:0] DEV_WR = 8'hD6;
    localparam logic [7:0] DEV_RD = 8'hD7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, busy, sda_bus;
    int   n_chk = 0;
    int   n_bad = 0;

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2cp_slave #(.WR_CYCLES(600)) u_dut (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_m),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe),
        .busy   (busy)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b0; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b1; qw();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qw();
            scl_m = 1'b1; qw(); qw();
            scl_m = 1'b0;
        end
        qw();
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        ack = ~sda_bus; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qw();
            scl_m = 1'b1; qw();
            b[i] = sda_bus; qw();
            scl_m = 1'b0; qw();
        end
        sda_m = ~give_ack; qw();
        scl_m = 1'b1; qw(); qw();
        scl_m = 1'b0; qw();
        sda_m = 1'b1;
    endtask

    task automatic wait_ready();
        repeat (20) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    task automatic wr_txn(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] d,
                          input logic exp_dack, input string req);
        logic a;
        bus_start();
        send_byte(DEV_WR, a); chk({req, " device ack"}, 8'(a), 8'd1);
        send_byte(hi, a);     chk({req, " addr-hi ack"}, 8'(a), 8'd1);
        send_byte(lo, a);     chk({req, " addr-lo ack"}, 8'(a), 8'd1);
        send_byte(d, a);      chk({req, " data ack"}, 8'(a), 8'(exp_dack));
        bus_stop();
    endtask

    task automatic rd_one(input logic [7:0] hi, input logic [7:0] lo, output logic [7:0] d);
        logic a;
        bus_start();
        send_byte(DEV_WR, a);
        send_byte(hi, a);
        send_byte(lo, a);
        bus_start();
        send_byte(DEV_RD, a); chk("R10 read device ack after repeated start", 8'(a), 8'd1);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic t_reset();
        chk("R11 sda_oe after reset", 8'(sda_oe), 8'd0);
        chk("R11 busy after reset", 8'(busy), 8'd0);
    endtask

    task automatic t_bad_address();
        logic a;
        bus_start();
        send_byte(8'hA6, a); chk("R1 wrong identifier nack", 8'(a), 8'd0);
        bus_stop();
        bus_start();
        send_byte(8'hD2, a); chk("R1 wrong select nack", 8'(a), 8'd0);
        bus_stop();
        chk("R1 no write interval", 8'(busy), 8'd0);
    endtask

    task automatic t_locked_write();
        logic [7:0] d;
        wr_txn(8'h00, 8'h05, 8'h5A, 1'b0, "R4 mem write locked");
        chk("R4 refused byte starts no write interval", 8'(busy), 8'd0);
        wait_ready();
        rd_one(8'h00, 8'h05, d);
        chk("R4 R11 memory unchanged (zero)", d, 8'h00);
    endtask

    task automatic t_unlock_and_busy();
        logic a;
        logic [7:0] d;
        wr_txn(8'h02, 8'h00, 8'h02, 1'b1, "R5 status 02h");
        chk("R8 busy after committing stop", 8'(busy), 8'd1);
        bus_start();
        send_byte(DEV_WR, a); chk("R8 address ignored while busy", 8'(a), 8'd0);
        chk("R8 still busy at collision", 8'(busy), 8'd1);
        bus_stop();
        wait_ready();
        rd_one(8'h02, 8'h00, d);
        chk("R5 status reads write-enable only", d, 8'h02);
    endtask

    task automatic t_mem_and_ctrl_gate();
        logic [7:0] d;
        wr_txn(8'h01, 8'h03, 8'h77, 1'b0, "R5 control write without control enable");
        chk("R5 refused control byte no interval", 8'(busy), 8'd0);
        wait_ready();
        wr_txn(8'h00, 8'h05, 8'h5A, 1'b1, "R2 mem write enabled");
        wait_ready();
        rd_one(8'h00, 8'h05, d);
        chk("R2 R6 memory readback", d, 8'h5A);
        rd_one(8'h01, 8'h03, d);
        chk("R5 control unchanged", d, 8'h00);
    endtask

    task automatic t_status_second_byte();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(DEV_WR, a);
        send_byte(8'h02, a);
        send_byte(8'h00, a);
        send_byte(8'h06, a); chk("R3 first status byte ack", 8'(a), 8'd1);
        send_byte(8'h00, a); chk("R3 second status byte nack", 8'(a), 8'd0);
        bus_stop();
        wait_ready();
        rd_one(8'h02, 8'h00, d);
        chk("R3 R5 status holds 06h", d, 8'h06);
    endtask

    task automatic t_ctrl_write();
        logic [7:0] d;
        wr_txn(8'h01, 8'h03, 8'hC3, 1'b1, "R5 control write unlocked");
        wait_ready();
        rd_one(8'h01, 8'h03, d);
        chk("R5 control readback", d, 8'hC3);
    endtask

    task automatic t_seq_wrap();
        logic a;
        logic [7:0] d;
        wr_txn(8'h00, 8'h3F, 8'hA5, 1'b1, "R9 setup last");
        wait_ready();
        wr_txn(8'h00, 8'h00, 8'h3C, 1'b1, "R9 setup first");
        wait_ready();
        bus_start();
        send_byte(DEV_WR, a);
        send_byte(8'h00, a);
        send_byte(8'h3F, a);
        bus_start();
        send_byte(DEV_RD, a);
        recv_byte(1'b1, d); chk("R6 first sequential byte", d, 8'hA5);
        recv_byte(1'b1, d); chk("R9 wrap to index 0", d, 8'h3C);
        recv_byte(1'b0, d); chk("R9 index 1 after wrap", d, 8'h00);
        bus_stop();
    endtask

    task automatic t_nack_release();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(DEV_WR, a);
        send_byte(8'h00, a);
        send_byte(8'h05, a);
        bus_start();
        send_byte(DEV_RD, a);
        recv_byte(1'b0, d); chk("R6 byte before nack", d, 8'h5A);
        chk("R7 line released after nack", 8'(sda_oe), 8'd0);
        recv_byte(1'b0, d); chk("R7 no data after nack", d, 8'hFF);
        bus_stop();
    endtask

    task automatic t_rstart_discard();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(DEV_WR, a);
        send_byte(8'h00, a);
        send_byte(8'h07, a);
        send_byte(8'h11, a); chk("R10 pending data ack", 8'(a), 8'd1);
        bus_start();
        send_byte(DEV_RD, a); chk("R10 address rechecked", 8'(a), 8'd1);
        recv_byte(1'b0, d); chk("R10 old value before commit", d, 8'h00);
        bus_stop();
        chk("R10 discarded byte starts no interval", 8'(busy), 8'd0);
        rd_one(8'h00, 8'h07, d);
        chk("R10 byte never written", d, 8'h00);
    endtask

    task automatic t_relock();
        logic [7:0] d;
        wr_txn(8'h02, 8'h00, 8'h00, 1'b1, "R5 status clear");
        wait_ready();
        rd_one(8'h02, 8'h00, d);
        chk("R5 status cleared", d, 8'h00);
        wr_txn(8'h00, 8'h05, 8'h99, 1'b0, "R4 mem write relocked");
        wait_ready();
        rd_one(8'h00, 8'h05, d);
        chk("R4 memory kept", d, 8'h5A);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_bad_address();
        t_locked_write();
        t_unlock_and_busy();
        t_mem_and_ctrl_gate();
        t_status_second_byte();
        t_ctrl_write();
        t_seq_wrap();
        t_nack_release();
        t_rstart_discard();
        t_relock();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule